// File: doc/BRIEF.md
# Host Register Bank with Receive and Transmit FIFO Windows

This block is a byte-wide register file placed behind a simple host strobe port, as a serial byte engine would drive it. Host writes carry their own address. Host reads always come from the address held in an internal read-pointer register. Two 64-byte buffers are each reached through one address. Repeated host reads of the receive window drain the receive buffer, which the modem side fills. Repeated host writes of the transmit window fill the transmit buffer, which the modem side drains.

A command register sets any of the four buffer pointers back to zero and leaves the stored bytes alone. This lets the host replay a buffer or discard it. Four modem event pulses are latched into a status register. Each latched event is gated by its own enable bit, and the gated events are ORed onto a single interrupt line. The management-ready enable comes out of reset set, and its event is already pending, so the interrupt is asserted as soon as reset ends.

Top module: `regbank_fifo_win`

## Requirements
- R1: After reset the read pointer is 0x00, both buffers are empty and `m_tx_valid` is 0.
- R2: Writing address 0x00 loads the read pointer. A host read returns, on `h_rd_data` one cycle after `h_rd_en`, the register at the read pointer, and the pointer then increments by one, wrapping from 0xFF to 0x00. Read map: 0x00 pointer, 0x01 receive window, 0x02 reads 0x00, 0x03 last command code in bits [2:0], 0x04 enables in bits [3:0], 0x05 pending events in bits [3:0], any other address reads 0x00.
- R3: While the read pointer is 0x01, a read does not move the pointer. Each such read returns the oldest unread receive byte and consumes it.
- R4: A receive-window read of an empty receive buffer returns 0x00 and consumes nothing. A modem push (`m_rx_push`) into a full receive buffer of 64 bytes is dropped.
- R5: A host write to 0x02 appends a byte to the transmit buffer. `m_tx_data` shows the oldest byte while `m_tx_valid` is 1. `m_tx_pop` consumes that byte and has no effect when the buffer is empty.
- R6: A host write to 0x02 while the transmit buffer holds 64 bytes is dropped.
- R7: A write to 0x03 clears pointers by the code in bits [2:0]: 001 or 101 clears the receive read pointer, 010 or 110 the receive write pointer, 011 the transmit read pointer, 100 the transmit write pointer, and 000 clears none. Buffer contents are kept.
- R8: Code 111 at 0x03 clears all four pointers at once, which empties both buffers.
- R9: `ev_in[3:0]` pulses set pending bits: bit0 transmit done, bit1 packet received, bit2 channel assessment ready, bit3 management ready. Writing 1s to 0x05 clears the matching pending bits, and a new event in the same cycle wins over the clear. `irq` is the OR of the pending bits ANDed with the enables at 0x04.
- R10: Reset sets the enables to 0x08 and the pending bits to 0x08, so `irq` is 1 right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_wr_addr | input | 8 | Host write address |
| h_wr_data | input | 8 | Host write data |
| h_rd_en | input | 1 | Host read strobe, reads at the read pointer |
| h_rd_data | output | 8 | Host read data, registered |
| m_rx_push | input | 1 | Modem push into the receive buffer |
| m_rx_data | input | 8 | Modem receive byte |
| m_tx_pop | input | 1 | Modem pop from the transmit buffer |
| m_tx_data | output | 8 | Oldest transmit byte |
| m_tx_valid | output | 1 | Transmit buffer not empty |
| ev_in | input | 4 | Modem event pulses |
| irq | output | 1 | Combined masked interrupt |

## Verification
Every register and pointer update takes effect at the clock edge that samples the strobe. `h_rd_data` holds the value of the register at the read pointer at that same edge. `irq`, `m_tx_data` and `m_tx_valid` follow combinationally from registers, so each of them is due right after the edge that updates its source. The bench drives strobes on the falling edge, leaves them in place for exactly one rising edge, and samples on the next falling edge. Every expected value therefore belongs to the single edge that lies in between.

// File: rtl/regbank_fifo_win.sv
module regbank_fifo_win #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int NEV   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr_en,
  input  logic [7:0]    h_wr_addr,
  input  logic [DW-1:0] h_wr_data,
  input  logic          h_rd_en,
  output logic [DW-1:0] h_rd_data,
  input  logic          m_rx_push,
  input  logic [DW-1:0] m_rx_data,
  input  logic          m_tx_pop,
  output logic [DW-1:0] m_tx_data,
  output logic          m_tx_valid,
  input  logic [NEV-1:0] ev_in,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [7:0] A_PTR = 8'h00, A_RX = 8'h01, A_TX = 8'h02,
                         A_CTL = 8'h03, A_EN = 8'h04, A_ST = 8'h05;
  localparam logic [NEV-1:0] BOOT = NEV'(1) << (NEV-1);

  logic [7:0]    rd_ptr;
  logic [2:0]    ctl_code;
  logic [NEV-1:0] irq_en, pend;
  logic [PW:0]   rx_rp, rx_wp, tx_rp, tx_wp;
  logic [DW-1:0] rx_mem [DEPTH];
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rd_mux;

  wire wr_ptr = h_wr_en && h_wr_addr == A_PTR;
  wire wr_tx  = h_wr_en && h_wr_addr == A_TX;
  wire wr_ctl = h_wr_en && h_wr_addr == A_CTL;
  wire wr_en  = h_wr_en && h_wr_addr == A_EN;
  wire wr_st  = h_wr_en && h_wr_addr == A_ST;
  wire [2:0] code = h_wr_data[2:0];

  wire clr_rxr = wr_ctl && (code == 3'd1 || code == 3'd5 || code == 3'd7);
  wire clr_rxw = wr_ctl && (code == 3'd2 || code == 3'd6 || code == 3'd7);
  wire clr_txr = wr_ctl && (code == 3'd3 || code == 3'd7);
  wire clr_txw = wr_ctl && (code == 3'd4 || code == 3'd7);

  wire rx_empty = rx_rp == rx_wp;
  wire tx_empty = tx_rp == tx_wp;
  wire rx_full  = (rx_rp[PW] != rx_wp[PW]) && (rx_rp[PW-1:0] == rx_wp[PW-1:0]);
  wire tx_full  = (tx_rp[PW] != tx_wp[PW]) && (tx_rp[PW-1:0] == tx_wp[PW-1:0]);

  wire rx_pop  = h_rd_en && rd_ptr == A_RX && !rx_empty;
  wire rx_push = m_rx_push && !rx_full;
  wire tx_push = wr_tx && !tx_full;
  wire tx_pop  = m_tx_pop && !tx_empty;

  assign m_tx_data  = tx_mem[tx_rp[PW-1:0]];
  assign m_tx_valid = !tx_empty;
  assign irq        = |(pend & irq_en);

  always_comb begin
    case (rd_ptr)
      A_PTR:   rd_mux = DW'(rd_ptr);
      A_RX:    rd_mux = rx_empty ? '0 : rx_mem[rx_rp[PW-1:0]];
      A_CTL:   rd_mux = DW'(ctl_code);
      A_EN:    rd_mux = DW'(irq_en);
      A_ST:    rd_mux = DW'(pend);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      h_rd_data <= '0;
      ctl_code  <= '0;
      irq_en    <= BOOT;
      pend      <= BOOT;
    end else begin
      if (wr_ptr)                        rd_ptr <= h_wr_data;
      else if (h_rd_en && rd_ptr != A_RX) rd_ptr <= rd_ptr + 8'd1;
      if (h_rd_en) h_rd_data <= rd_mux;
      if (wr_ctl)  ctl_code  <= code;
      if (wr_en)   irq_en    <= h_wr_data[NEV-1:0];
      pend <= (wr_st ? (pend & ~h_wr_data[NEV-1:0]) : pend) | ev_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rp <= '0; rx_wp <= '0; tx_rp <= '0; tx_wp <= '0;
    end else begin
      if (clr_rxr)      rx_rp <= '0;
      else if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      if (clr_rxw)      rx_wp <= '0;
      else if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (clr_txr)      tx_rp <= '0;
      else if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (clr_txw)      tx_wp <= '0;
      else if (tx_push) tx_wp <= tx_wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp[PW-1:0]] <= m_rx_data;
    if (tx_push) tx_mem[tx_wp[PW-1:0]] <= h_wr_data;
  end
endmodule

// File: rtl/regbank_fifo_win_chk.sv
module regbank_fifo_win_chk #(
  parameter int DW  = 8,
  parameter int PW  = 6,
  parameter int NEV = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr_en,
  input logic [7:0]    h_wr_addr,
  input logic [DW-1:0] h_wr_data,
  input logic          h_rd_en,
  input logic [DW-1:0] h_rd_data,
  input logic [NEV-1:0] ev_in,
  input logic          irq,
  input logic [7:0]    rd_ptr,
  input logic [NEV-1:0] irq_en,
  input logic          rx_empty,
  input logic          tx_full,
  input logic [PW:0]   rx_rp,
  input logic [PW:0]   rx_wp,
  input logic [PW:0]   tx_rp,
  input logic [PW:0]   tx_wp
);
  wire w0 = h_wr_en && h_wr_addr == 8'h00;

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_en && !w0 && rd_ptr != 8'h01 |=> rd_ptr == $past(rd_ptr) + 8'd1);

  assert_ptr_stay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_en && !w0 && rd_ptr == 8'h01 |=> rd_ptr == 8'h01);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_en && rd_ptr == 8'h01 && rx_empty && !(h_wr_en && h_wr_addr == 8'h03)
    |=> h_rd_data == '0 && $stable(rx_rp));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_en && h_wr_addr == 8'h02 && tx_full |=> $stable(tx_wp));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_en && h_wr_addr == 8'h03 && h_wr_data[2:0] == 3'd7
    |=> rx_rp == '0 && rx_wp == '0 && tx_rp == '0 && tx_wp == '0);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_in & irq_en)) && !(h_wr_en && h_wr_addr == 8'h04) |=> irq);
endmodule

bind regbank_fifo_win regbank_fifo_win_chk #(.DW(DW), .PW(PW), .NEV(NEV)) u_chk (.*);

// File: tb/sim_regbank_fifo_win.sv
`timescale 1ns/1ps
module sim_regbank_fifo_win;
  logic clk = 0, rst_n = 0;
  logic h_wr_en = 0, h_rd_en = 0, m_rx_push = 0, m_tx_pop = 0;
  logic [7:0] h_wr_addr = 0, h_wr_data = 0, m_rx_data = 0;
  logic [3:0] ev_in = 0;
  logic [7:0] h_rd_data, m_tx_data;
  logic m_tx_valid, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  regbank_fifo_win u0 (.*);

  localparam int NV = 29;
  // {op: 0 write, 1 read-check, 2 modem push; addr; data; expected}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0,8'h04,8'h0F,8'h00}, {2'd0,8'h00,8'h04,8'h00},
    {2'd1,8'h00,8'h00,8'h0F}, {2'd1,8'h00,8'h00,8'h08},
    {2'd1,8'h00,8'h00,8'h00}, {2'd0,8'h03,8'h00,8'h00},
    {2'd0,8'h00,8'h03,8'h00}, {2'd1,8'h00,8'h00,8'h00},
    {2'd2,8'h00,8'hAA,8'h00}, {2'd2,8'h00,8'hBB,8'h00},
    {2'd2,8'h00,8'hCC,8'h00}, {2'd0,8'h00,8'h01,8'h00},
    {2'd1,8'h00,8'h00,8'hAA}, {2'd1,8'h00,8'h00,8'hBB},
    {2'd0,8'h03,8'h01,8'h00}, {2'd1,8'h00,8'h00,8'hAA},
    {2'd0,8'h03,8'h00,8'h00}, {2'd1,8'h00,8'h00,8'hBB},
    {2'd0,8'h03,8'h05,8'h00}, {2'd1,8'h00,8'h00,8'hAA},
    {2'd1,8'h00,8'h00,8'hBB}, {2'd1,8'h00,8'h00,8'hCC},
    {2'd1,8'h00,8'h00,8'h00}, {2'd1,8'h00,8'h00,8'h00},
    {2'd0,8'h00,8'h03,8'h00}, {2'd1,8'h00,8'h00,8'h05},
    {2'd1,8'h00,8'h00,8'h0F}, {2'd0,8'h00,8'h02,8'h00},
    {2'd1,8'h00,8'h00,8'h00}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    h_wr_en = 1; h_wr_addr = a; h_wr_data = d;
    @(negedge clk); h_wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] exp, input string what);
    h_rd_en = 1;
    @(negedge clk); h_rd_en = 0;
    chk(h_rd_data, exp, what);
  endtask

  task automatic push(input logic [7:0] d);
    m_rx_push = 1; m_rx_data = d;
    @(negedge clk); m_rx_push = 0;
  endtask

  task automatic pop();
    m_tx_pop = 1;
    @(negedge clk); m_tx_pop = 0;
  endtask

  task automatic pulse(input logic [3:0] e);
    ev_in = e;
    @(negedge clk); ev_in = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({7'd0, m_tx_valid}, 8'h00, "R1 tx empty after reset");
    chk({7'd0, irq}, 8'h01, "R10 irq after reset");
    rd(8'h00, "R1 pointer reads 0 after reset");

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      case (v[25:24])
        2'd0: wr(v[23:16], v[15:8]);
        2'd2: push(v[15:8]);
        default: rd(v[7:0], $sformatf("R2 R3 R4 R7 table step %0d", i));
      endcase
    end

    // R10/R9 interrupt latch and clear
    wr(8'h05, 8'h0F);
    chk({7'd0, irq}, 8'h00, "R9 w1c clears boot event");
    pulse(4'b0001);
    chk({7'd0, irq}, 8'h01, "R9 enabled event raises irq");
    wr(8'h00, 8'h05);
    rd(8'h01, "R9 pending bit0");
    wr(8'h05, 8'h01);
    chk({7'd0, irq}, 8'h00, "R9 w1c bit0");
    wr(8'h04, 8'h00);
    pulse(4'b0100);
    chk({7'd0, irq}, 8'h00, "R9 masked event no irq");
    h_wr_en = 1; h_wr_addr = 8'h05; h_wr_data = 8'h02; ev_in = 4'b0010;
    @(negedge clk); h_wr_en = 0; ev_in = 0;
    wr(8'h00, 8'h05);
    rd(8'h06, "R9 set wins over clear");
    wr(8'h04, 8'h02);
    chk({7'd0, irq}, 8'h01, "R9 enabling pending source raises irq");

    // R5 and R7 on the transmit side
    wr(8'h03, 8'h07);
    wr(8'h02, 8'h11);
    wr(8'h02, 8'h22);
    chk({7'd0, m_tx_valid}, 8'h01, "R5 tx valid");
    chk(m_tx_data, 8'h11, "R5 tx head");
    pop();
    chk(m_tx_data, 8'h22, "R5 tx after pop");
    wr(8'h03, 8'h03);
    chk(m_tx_data, 8'h11, "R7 tx read clear keeps data");
    wr(8'h03, 8'h04);
    chk({7'd0, m_tx_valid}, 8'h00, "R7 tx write clear empties");
    wr(8'h02, 8'h33);
    chk(m_tx_data, 8'h33, "R7 tx write after clear");

    // R7 receive write clear aliases
    wr(8'h03, 8'h07);
    push(8'h55); push(8'h66);
    wr(8'h03, 8'h06);
    wr(8'h00, 8'h01);
    rd(8'h00, "R7 code 110 clears rx write pointer");
    push(8'h77);
    rd(8'h77, "R7 rx refill after clear");
    wr(8'h03, 8'h07);
    push(8'h12);
    wr(8'h03, 8'h02);
    rd(8'h00, "R7 code 010 clears rx write pointer");

    // R8 clear all
    push(8'h44);
    wr(8'h02, 8'h45);
    wr(8'h03, 8'h07);
    rd(8'h00, "R8 rx empty after clear all");
    chk({7'd0, m_tx_valid}, 8'h00, "R8 tx empty after clear all");

    // R6 transmit full, R5 pop on empty
    for (int i = 0; i < 65; i++) wr(8'h02, 8'(i));
    for (int i = 0; i < 64; i++) begin
      chk({7'd0, m_tx_valid}, 8'h01, "R6 tx valid while draining");
      chk(m_tx_data, 8'(i), "R6 tx order");
      pop();
    end
    chk({7'd0, m_tx_valid}, 8'h00, "R6 65th byte dropped");
    pop();
    wr(8'h02, 8'hEE);
    chk(m_tx_data, 8'hEE, "R5 pop on empty ignored");

    // R4 receive full
    wr(8'h03, 8'h07);
    for (int i = 0; i < 65; i++) push(8'(i + 1));
    for (int i = 0; i < 64; i++) rd(8'(i + 1), "R4 rx order to full");
    rd(8'h00, "R4 push into full rx dropped");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule